// File: doc/BRIEF.md
# Multi-Channel Wavelet Slot Scheduler

This block sequences one shared lifting-wavelet core over many channels and several decomposition levels. The channels arrive one after another on one sample bus. A single free-running counter drives every control output. Its low bits step through eight phases of one computation slot. The next bits name the channel. One further bit tells whether the round carries the first or the second sample of each channel's pair. The top bits count completed pair rounds.

In a second-sample slot the core runs a level-1 step on the pair. In a first-sample slot the core has no level-1 work, so that slot is given to at most one higher level. The level is taken from the round count, so the higher levels never raise the clock rate. The level of each slot is shown one-hot. Every level emits its detail coefficient. Only the top level also emits its approximation; the lower levels keep theirs for the next level. The arithmetic, the sample buffer and the state memories sit outside this block.

Top module: `wavelet_sched`

## Requirements
- R1: During reset and in the first cycle after it, `phase` and `chan` are 0 and the slot is idle. After that, `phase` steps 0 to 7 by one on every clock and then wraps.
- R2: `chan` advances by one when `phase` wraps, and wraps after NCH channels. Channel rounds alternate: first a first-sample round, then a second-sample round. One pair round is 16*NCH cycles.
- R3: `in_valid` at phase 0 of a first-sample round raises `buf_wr` (the sample goes to the buffer). At phase 0 of a second-sample round it raises `core_take` (the sample goes to the core). `in_valid` in any other phase raises neither strobe.
- R4: Every slot of a second-sample round runs level 1, so `lvl_oh` is 1 (bit n-1 marks level n).
- R5: In a first-sample slot, let q be the completed pair rounds modulo 2^NLVL, and let z be the number of trailing zero bits of q. The slot runs level z+2 when three conditions hold: q is not 0, z+2 is at most NLVL, and either q is not a power of two or at least 2^NLVL pair rounds have completed since reset. Otherwise the slot is idle and `lvl_oh` is 0.
- R6: A level-n slot (n of 2 or more) is scheduled only when that channel holds at least two level-(n-1) results that no earlier slot has used.
- R7: In a slot that is not idle, `mem_rd` is high at phase 0. `core_en` is high at phases 1 to 5, with `step` = phase-1. `mem_wr` is high at phases 6 and 7, with `wr_sel` 0 at phase 6 and 1 at phase 7. In an idle slot all four strobes stay low.
- R8: A slot that is not idle raises `out_valid` with `out_approx`=0 at phase 5 (the detail). A top-level slot also raises `out_valid` with `out_approx`=1 at phase 6 (the approximation). No other cycle raises `out_valid`.
- R9: `lvl_oh` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present on the shared bus |
| phase | output | 3 | Phase within the current slot |
| chan | output | CW | Channel of the current slot |
| buf_wr | output | 1 | Write the arriving sample into the input buffer |
| core_take | output | 1 | Steer the arriving sample directly into the core |
| lvl_oh | output | NLVL | One-hot level of the current slot, 0 when idle |
| mem_rd | output | 1 | Read the channel/level state |
| core_en | output | 1 | Core computes this cycle |
| step | output | 3 | Core step index |
| mem_wr | output | 1 | Write back state |
| wr_sel | output | 1 | Selects which of the two write-back cycles this is |
| out_valid | output | 1 | A coefficient leaves the core |
| out_approx | output | 1 | The coefficient is an approximation, not a detail |

## Verification
The hardest case to reach is the change of schedule once the round counter first wraps. Before the wrap, the first slot of each level is suppressed because its inputs do not exist yet. After the wrap, those power-of-two rounds must carry real work. The bench runs past 2^NLVL complete pair rounds, so both the start-up behaviour and the steady behaviour are covered. It also keeps a per-channel count of unused results at each level and checks every scheduled slot against those counts. Stray `in_valid` pulses are placed in phases other than phase 0, and some phase-0 pulses are left out.

// File: rtl/wavelet_sched.sv
module wavelet_sched #(
  parameter int NCH  = 32,
  parameter int NLVL = 4,
  localparam int CW  = $clog2(NCH),
  localparam int TW  = 3 + CW + 1 + NLVL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic [2:0]      phase,
  output logic [CW-1:0]   chan,
  output logic            buf_wr,
  output logic            core_take,
  output logic [NLVL-1:0] lvl_oh,
  output logic            mem_rd,
  output logic            core_en,
  output logic [2:0]      step,
  output logic            mem_wr,
  output logic            wr_sel,
  output logic            out_valid,
  output logic            out_approx
);

  logic [TW-1:0]   cnt;
  logic            lap;
  logic            half, active, first, top;
  logic [NLVL-1:0] q;
  logic [NLVL-2:0] lsb;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lap <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (&cnt) lap <= 1'b1;
    end
  end

  assign phase = cnt[2:0];
  assign chan  = cnt[3 +: CW];
  assign half  = cnt[3 + CW];
  assign q     = cnt[TW-1 -: NLVL];
  assign lsb   = q[NLVL-2:0] & (~q[NLVL-2:0] + 1'b1);

  assign lvl_oh = half ? NLVL'(1)
                : ((lap || q != {1'b0, lsb}) ? {lsb, 1'b0} : '0);

  assign active = |lvl_oh;
  assign first  = (phase == 3'd0);
  assign top    = lvl_oh[NLVL-1];

  assign buf_wr    = in_valid & first & ~half;
  assign core_take = in_valid & first & half;

  assign mem_rd  = active & first;
  assign core_en = active & (phase >= 3'd1) & (phase <= 3'd5);
  assign step    = core_en ? phase - 3'd1 : 3'd0;
  assign mem_wr  = active & phase[2] & phase[1];
  assign wr_sel  = mem_wr & phase[0];

  assign out_approx = active & top & (phase == 3'd6);
  assign out_valid  = (active & (phase == 3'd5)) | out_approx;

endmodule

module wavelet_sched_chk #(
  parameter int NLVL = 4,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      phase,
  input logic [CW-1:0]   chan,
  input logic            buf_wr,
  input logic            core_take,
  input logic [NLVL-1:0] lvl_oh,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            out_valid,
  input logic            out_approx
);

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase == 3'($past(phase) + 3'd1));

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phase != 3'd7 |=> $stable(chan));

  // R3
  steer_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(buf_wr && core_take));

  // R3
  steer_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_wr || core_take) |-> phase == 3'd0);

  // R9
  lvl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lvl_oh));

  // R2
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phase != 3'd7 |=> $stable(lvl_oh));

  // R7
  rd_wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> lvl_oh != '0);

  // R8
  approx_top_chk: assert property (@(posedge clk) disable iff (rst)
    out_approx |-> out_valid && lvl_oh[NLVL-1] && phase == 3'd6);

  // R8
  out_phase_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (phase == 3'd5 || phase == 3'd6) && lvl_oh != '0);

endmodule

bind wavelet_sched wavelet_sched_chk #(.NLVL(NLVL), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .chan(chan), .buf_wr(buf_wr),
  .core_take(core_take), .lvl_oh(lvl_oh), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .out_valid(out_valid), .out_approx(out_approx)
);

// File: tb/sim_wavelet_sched.sv
`timescale 1ns/1ps
module sim_wavelet_sched;
  localparam int NCH  = 32;
  localparam int NLVL = 4;
  localparam int CW   = $clog2(NCH);
  localparam int PAIRS = 40;
  localparam int CYCLES = PAIRS * 16 * NCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] phase, step;
  logic [CW-1:0] chan;
  logic buf_wr, core_take, mem_rd, core_en, mem_wr, wr_sel, out_valid, out_approx;
  logic [NLVL-1:0] lvl_oh;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int avail [NCH][NLVL+1];

  always #4 clk = ~clk;

  wavelet_sched #(.NCH(NCH), .NLVL(NLVL)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase), .chan(chan),
    .buf_wr(buf_wr), .core_take(core_take), .lvl_oh(lvl_oh), .mem_rd(mem_rd),
    .core_en(core_en), .step(step), .mem_wr(mem_wr), .wr_sel(wr_sel),
    .out_valid(out_valid), .out_approx(out_approx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp, input int t);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, t, act, exp);
    end
  endtask

  function automatic int exp_level(input int t);
    int rnd, pr, q, z;
    rnd = t / (8 * NCH);
    if (rnd % 2 == 1) return 1;
    pr = rnd / 2;
    q  = pr % (1 << NLVL);
    if (q == 0) return 0;
    z = 0;
    while ((q % 2) == 0) begin q = q / 2; z++; end
    q = pr % (1 << NLVL);
    if (z + 2 > NLVL) return 0;
    if (pr < (1 << NLVL) && q == (1 << z)) return 0;
    return z + 2;
  endfunction

  task automatic check_cycle(input int t, input bit vin, input bit in_rst);
    int ph, ch, hf, elv, olv;
    ph  = t % 8;
    ch  = (t / 8) % NCH;
    hf  = (t / (8 * NCH)) % 2;
    elv = in_rst ? 0 : exp_level(t);
    chk("R1", "phase", phase, ph, t);
    chk("R2", "chan", chan, ch, t);
    chk(hf ? "R4" : "R5", "lvl_oh", lvl_oh, (elv == 0) ? 0 : (1 << (elv - 1)), t);
    chk("R3", "buf_wr", buf_wr, vin && ph == 0 && hf == 0, t);
    chk("R3", "core_take", core_take, vin && ph == 0 && hf == 1, t);
    chk("R7", "mem_rd", mem_rd, elv != 0 && ph == 0, t);
    chk("R7", "core_en", core_en, elv != 0 && ph >= 1 && ph <= 5, t);
    if (elv != 0 && ph >= 1 && ph <= 5) chk("R7", "step", step, ph - 1, t);
    chk("R7", "mem_wr", mem_wr, elv != 0 && ph >= 6, t);
    chk("R7", "wr_sel", wr_sel, elv != 0 && ph == 7, t);
    chk("R8", "out_valid", out_valid, elv != 0 && (ph == 5 || (ph == 6 && elv == NLVL)), t);
    chk("R8", "out_approx", out_approx, elv == NLVL && ph == 6, t);
    if (!in_rst && ph == 0) begin
      olv = 0;
      for (int b = 0; b < NLVL; b++) if (lvl_oh[b]) olv = b + 1;
      if (olv >= 2) begin
        chk("R6", "unused lower results", avail[chan][olv-1] >= 2, 1, t);
        avail[chan][olv-1] -= 2;
      end
      if (olv >= 1) avail[chan][olv]++;
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int l = 0; l <= NLVL; l++) avail[c][l] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    check_cycle(0, 1'b1, 1'b1);
    in_valid = 1'b0;
    rst = 1'b0;
    for (int t = 0; t < CYCLES; t++) begin
      bit vin;
      vin = ((t % 8) == 0 && ((t / 8) % 5) != 3) || ((t % 8) == 3 && ((t / 8) % 7) == 2)
            || ((t % 8) == 6 && ((t / 8) % 11) == 4);
      in_valid = vin;
      #1;
      check_cycle(t, vin, 1'b0);
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * (CYCLES + 2000));
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule